// File: doc/BRIEF.md
# Reload Down-Counter Timer

This block is a 16-bit programmable timer that counts down on a divided copy of the system clock. Software writes a start value into a reload register, picks a divider, chooses one-shot or auto-repeat behaviour, and sets a run bit. On the first divided tick after the run bit is set, the start value is copied into the counter. Each later tick takes one off the counter. When the counter steps from 1 to 0, a sticky end flag is set, and an interrupt line rises if interrupts are allowed.

In one-shot mode the counter then stays at zero. In repeat mode the next tick copies the start value in again and the count goes on. Clearing the run bit freezes the counter and resets the divider, so a new run starts from a known phase.

Each copy of the block is self-contained, so several timers can sit side by side on one bus.

Register map, with the address on `addr`:

| Address | Meaning |
|---|---|
| 0 | Control. Bit 0 is run. Bit 1 is repeat mode (0 for one-shot). Bits 3:2 select the divider. Bit 4 is interrupt enable. |
| 1 | Start value |
| 2 | Current count, read-only |
| 3 | Status. Bit 0 is the end flag. |

Unused read bits return 0.

Top module: `reload_timer`

## Requirements
- R1: After reset, every register reads as 0 and `irq` is low. A value written to the control address reads back on bits 4:0 of `rdata`.
- R2: The divider select field, control bits 3:2, picks the tick rate. Code 0 gives one tick per 4 clocks, code 1 per 16, code 2 per 64 and code 3 per 256. The first tick comes N clocks after the rising edge that stores run=1.
- R3: The first tick after run is set copies the start value into the counter.
- R4: Each later tick lowers the count by one. A start value of 0 behaves as 65536: it is loaded as 0, and the next tick gives 0xFFFF.
- R5: The tick that moves the count from 1 to 0 sets the sticky end flag, which is status bit 0. `irq` is high exactly while the flag and interrupt enable are both 1.
- R6: In one-shot mode (control bit 1 = 0) the count stays at 0 after the end and changes no further.
- R7: In repeat mode (control bit 1 = 1) the tick after the count reaches 0 loads the start value again. Successive ends are therefore (start value + 1) ticks apart.
- R8: While run is 0, the count holds its value and the divider is reset. A later run loads the start value on its Nth clock.
- R9: The end flag clears on the clock edge that samples a read access (`rd_en`) or a write access (`wr_en`) at the status address.
- R10: Reading the current count, at any time, does not change the count sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe. It only has an effect at the status address, where it clears the flag. |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data. It is combinational from `addr`. |
| irq | output | 1 | Interrupt request: end flag AND interrupt enable |

## Verification
A control write sampled at edge k makes the start value visible on the count at edge k+N. Each later tick is N edges further on. The end flag and `irq` change on the same edge as the 1-to-0 step, and a flag clear shows on the edge that samples the access.

`rdata` is combinational, so a read shows state from the last edge. The bench drives and samples at falling edges. Before each sample it counts the edges since the enabling write, m. It turns m into a tick count, floor(m/N), and from that computes the expected count and flag in closed form. Every run is stopped at a random point in the divider period, so the next run shows whether the divider was reset.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

    localparam int SEL_W = 2;
    localparam int ADDR_W = 2;

    // Control register layout, LSB last: run at bit 0, irq_en at bit 4
    typedef struct packed {
        logic             irq_en;
        logic [SEL_W-1:0] div_sel;
        logic             cont;
        logic             run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

endpackage

// File: rtl/reload_timer_prescaler.sv
module reload_timer_prescaler #(
    parameter int TAP_STEP = 2,
    parameter int SEL_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic [SEL_W-1:0]                sel,
    output logic                            tick,
    output logic [TAP_STEP*(2**SEL_W)-1:0]  pre_val
);
    localparam int NUM_TAPS = 2 ** SEL_W;
    localparam int PRE_W    = TAP_STEP * NUM_TAPS;

    logic [PRE_W-1:0]    pre_d, pre_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Tap i fires when the low TAP_STEP*(i+1) bits are all ones
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_hit[i] = &pre_q[TAP_STEP*(i+1)-1:0];
    end

    always_comb begin
        pre_d = run ? pre_q + 1'b1 : '0;
        tick  = run & tap_hit[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign pre_val = pre_q;

endmodule

// File: rtl/reload_timer_core.sv
module reload_timer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cont,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             loaded,
    output logic             done,
    output logic             end_pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             loaded;
        logic             done;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        end_pulse = 1'b0;
        if (!run) begin
            st_d.loaded = 1'b0;
            st_d.done   = 1'b0;
        end else if (tick) begin
            if (!st_q.loaded) begin
                st_d.count  = reload;
                st_d.loaded = 1'b1;
                st_d.done   = 1'b0;
            end else if (st_q.done) begin
                if (cont) begin
                    st_d.count = reload;
                    st_d.done  = 1'b0;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
                if (st_q.count == CNT_W'(1)) begin
                    st_d.done = 1'b1;
                    end_pulse = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count  = st_q.count;
    assign loaded = st_q.loaded;
    assign done   = st_q.done;

endmodule

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              end_pulse,
    output ctl_t              ctl,
    output logic [CNT_W-1:0]  reload,
    output logic              flag,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] reload;
        logic             flag;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (addr)
                A_CTRL:   rg_d.ctl    = ctl_t'(wdata[CTL_W-1:0]);
                A_RELOAD: rg_d.reload = wdata;
                A_STATUS: rg_d.flag   = 1'b0;
                default:  ;
            endcase
        end
        if (rd_en && addr == A_STATUS) rg_d.flag = 1'b0;
        // a new end of count wins over a clear in the same cycle
        if (end_pulse) rg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[CTL_W-1:0] = rg_q.ctl;
            A_RELOAD: rdata = rg_q.reload;
            A_COUNT:  rdata = count;
            default:  rdata[0] = rg_q.flag;
        endcase
    end

    assign ctl    = rg_q.ctl;
    assign reload = rg_q.reload;
    assign flag   = rg_q.flag;
    assign irq    = rg_q.flag & rg_q.ctl.irq_en;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import reload_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TAP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    localparam int PRE_W = TAP_STEP * (2 ** SEL_W);

    ctl_t             ctl_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    logic             flag_w;
    logic             tick_w;
    logic             loaded_w;
    logic             done_w;
    logic             end_w;
    logic [PRE_W-1:0] pre_w;

    reload_timer_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .count     (count_w),
        .end_pulse (end_w),
        .ctl       (ctl_w),
        .reload    (reload_w),
        .flag      (flag_w),
        .rdata     (rdata),
        .irq       (irq)
    );

    reload_timer_prescaler #(.TAP_STEP(TAP_STEP), .SEL_W(SEL_W)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_w.run),
        .sel     (ctl_w.div_sel),
        .tick    (tick_w),
        .pre_val (pre_w)
    );

    reload_timer_core #(.CNT_W(CNT_W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_w.run),
        .cont      (ctl_w.cont),
        .tick      (tick_w),
        .reload    (reload_w),
        .count     (count_w),
        .loaded    (loaded_w),
        .done      (done_w),
        .end_pulse (end_w)
    );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cont,
    input logic             tick,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             loaded,
    input logic             done,
    input logic             flag,
    input logic [PRE_W-1:0] pre_val
);
    AST_LOAD_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !loaded) |=> (count == $past(reload)));              // R3

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && loaded && !done) |=> (count == $past(count) - CNT_W'(1))); // R4

    AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && loaded && !done && count == CNT_W'(1)) |=> flag);    // R5

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(run && tick && loaded && !done && count == CNT_W'(1))); // R5

    AST_SINGLE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && loaded && done && !cont) |=> $stable(count));                // R6

    AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && loaded && done && cont) |=> (count == $past(reload))); // R7

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> $stable(count));                                          // R8

    AST_STOP_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (pre_val == '0));                                         // R8

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_w.run),
    .cont    (ctl_w.cont),
    .tick    (tick_w),
    .reload  (reload_w),
    .count   (count_w),
    .loaded  (loaded_w),
    .done    (done_w),
    .flag    (flag_w),
    .pre_val (pre_w)
);

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
    import reload_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = A_COUNT;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int          checks = 0;
    int          failures = 0;
    logic [15:0] prev_count = '0;

    always #4 clk = ~clk;   // 125 MHz

    reload_timer dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected count after t ticks of a run with effective start value rp
    function automatic logic [15:0] exp_count(int t, int rp, bit cont, logic [15:0] old);
        int k;
        if (t == 0) return old;
        k = t - 1;
        if (!cont) return (k >= rp) ? 16'd0 : 16'(rp - k);
        return 16'(rp - (k % (rp + 1)));
    endfunction

    function automatic bit exp_flag(int t, int rp);
        return (t >= 1) && ((t - 1) >= rp);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = A_COUNT;
    endtask

    task automatic run_case(input int sel, input int r, input bit cont, input bit ie,
                            input int cyc, input bit clr_wr);
        int          n;
        int          rp;
        int          tf;
        logic [15:0] fin;
        logic [15:0] cw;
        n  = 4 << (2 * sel);
        rp = (r == 0) ? 65536 : r;
        cw = {11'd0, ie, sel[1:0], cont, 1'b1};
        wr(A_RELOAD, r[15:0]);
        wr(A_CTRL, cw);
        addr = A_CTRL;
        #1 chk("R1 control readback", rdata, cw);
        addr  = A_COUNT;
        rd_en = 1'b1;
        for (int m = 1; m <= cyc; m++) begin
            @(negedge clk);
            #1;
            // R2 R3 R4 R6 R7 R8 R10: count follows the tick sequence
            chk("R2/R3/R4/R6/R7/R8/R10 count", rdata, exp_count(m / n, rp, cont, prev_count));
            chk("R5 irq", irq, ie && exp_flag(m / n, rp));
        end
        rd_en = 1'b0;
        wr(A_CTRL, 16'd0);
        tf  = (cyc + 2) / n;
        fin = exp_count(tf, rp, cont, prev_count);
        #1 chk("R8 count after stop", rdata, fin);
        repeat (3) @(negedge clk);
        #1 chk("R8 count held while stopped", rdata, fin);
        addr = A_STATUS;
        #1 chk("R5 status flag", rdata, exp_flag(tf, rp));
        if (clr_wr) begin
            wr(A_STATUS, 16'd0);
            addr = A_STATUS;
            #1 chk("R9 status after write clear", rdata, 0);
        end else begin
            @(negedge clk);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            #1 chk("R9 status after read clear", rdata, 0);
        end
        chk("R9 irq after clear", irq, 0);
        addr = A_COUNT;
        prev_count = fin;
    endtask

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a);
            #1 chk("R1 reset register", rdata, 0);
        end
        chk("R1 reset irq", irq, 0);
        addr = A_COUNT;

        run_case(0, 5, 1'b0, 1'b1, 40, 1'b0);   // R6 one-shot, divide by 4
        run_case(1, 3, 1'b1, 1'b1, 200, 1'b0);  // R7 repeat, divide by 16
        run_case(2, 2, 1'b0, 1'b0, 260, 1'b0);  // R5 flag without irq, divide by 64
        run_case(3, 1, 1'b1, 1'b1, 1290, 1'b0); // R2 divide by 256
        run_case(0, 0, 1'b0, 1'b1, 41, 1'b0);   // R4 start value 0 wraps to 0xFFFF
        run_case(0, 2, 1'b0, 1'b1, 30, 1'b1);   // R9 write clear

        for (int i = 0; i < 24; i++) begin
            int sel;
            int r;
            int n;
            int rp;
            int cyc;
            sel = int'($urandom % 4);
            r   = int'($urandom % 13);
            n   = 4 << (2 * sel);
            rp  = (r == 0) ? 65536 : r;
            cyc = n * (rp + 1) * 2 + int'($urandom % n);
            if (cyc > 2500) cyc = 2500 + int'($urandom % n);
            run_case(sel, r, 1'($urandom), 1'($urandom), cyc, 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule